// File: doc/BRIEF.md
# Manchester Frame Encoder

This block turns a parallel data word into a Manchester-coded serial frame on one line. A word is handed over through a ready/valid pair. Along with the word come a field holding the bit count minus one, a polarity-convention select, a bit-order select and a start-field mode. Every bit is sent as two half-bit periods. Each half-bit period is `half_div + 1` system clocks long.

A frame is made of an optional start bit, the data bits and then two bit periods of high line. While no frame is being sent, the line rests high. A half-bit clock output runs alongside the coded bits. A one-cycle done pulse marks the end of a frame, and the block is ready again in that same cycle, so frames can follow each other with no gap.

Top module: `manchester_frame_tx`

## Requirements
- R1: After reset and between frames, `line_o` is 1, `hclk_o` is 0, `busy_o` is 0, `done_o` is 0 and `in_ready` is 1.
- R2: With `in_conv`=0, a bit of value 1 is sent as high then low, and a bit of value 0 as low then high.
- R3: With `in_conv`=1, a bit of value 1 is sent as low then high, and a bit of value 0 as high then low.
- R4: `in_len` holds the number of data bits minus one. A value of 0 sends exactly one data bit, and the largest value sends the whole word.
- R5: With `in_msb_first`=0, data bit 0 goes first. With `in_msb_first`=1, bit `in_len` goes first and bit 0 goes last.
- R6: `in_start_mode` sets the start field. Values 0 and 3 send no start bit. Value 1 sends a start bit coded as a data 0. Value 2 sends a start bit with inverted coding, which makes it look like a data 1. Data bits always use normal coding.
- R7: The last coded bit is followed by two full bit periods of high line, and `busy_o` stays 1 through them.
- R8: Each half-bit period lasts `half_div`+1 clocks, using the divider value captured when the word is accepted. The line changes only at half-bit boundaries. `hclk_o` is 1 in the first half and 0 in the second half of every coded bit.
- R9: A word is accepted on a clock where `in_valid` and `in_ready` are both 1, and `busy_o` rises in the next cycle. `done_o` is 1 for exactly the one cycle in which `busy_o` has just fallen. `in_ready` is 1 in that cycle, so a word offered then starts the next frame at once.
- R10: While `busy_o` is 1, `in_ready` is 0. Any `in_valid`, data, length, mode or divider value presented during that time has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word offered (start strobe) |
| in_ready | output | 1 | Encoder can take a word |
| in_data | input | DATA_W | Data word |
| in_len | input | LEN_W | Data bit count minus one |
| in_conv | input | 1 | Polarity convention select |
| in_msb_first | input | 1 | Send highest used bit first |
| in_start_mode | input | 2 | Start-field mode |
| half_div | input | DIV_W | Half-bit period minus one, in clocks |
| line_o | output | 1 | Coded line |
| hclk_o | output | 1 | Half-bit clock |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The end of one frame and the acceptance of the next word can fall in the same cycle. In that cycle `done_o` pulses while `in_ready` is 1. The bench provokes this by offering the next word at exactly the done cycle in chained runs. It then judges the result by two things: the done pulse is seen, and the following frame starts one cycle later with its line pattern intact. The other overlap is a strobe that arrives during a frame. The bench changes every input in the middle of a frame and expects the running frame's line, length and timing to stay exactly as computed from the original word.

// File: rtl/manchester_frame_tx.sv
module manchester_frame_tx #(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 16,
  localparam int LEN_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              in_conv,
  input  logic              in_msb_first,
  input  logic [1:0]        in_start_mode,
  input  logic [DIV_W-1:0]  half_div,
  output logic              line_o,
  output logic              hclk_o,
  output logic              busy_o,
  output logic              done_o
);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t               st_q;
  logic              half_q;
  logic [DIV_W-1:0]  cnt_q, div_q;
  logic [LEN_W-1:0]  idx_q, len_q;
  logic [1:0]        stop_q;
  logic [DATA_W-1:0] data_q;
  logic              conv_q, msb_q, sval_q, done_q;

  wire tick   = (cnt_q == div_q);
  wire coded  = (st_q == S_START) || (st_q == S_DATA);
  wire [LEN_W-1:0] pos = msb_q ? (len_q - idx_q) : idx_q;
  wire bit_v  = (st_q == S_START) ? sval_q : data_q[pos];
  wire lvl    = bit_v ^ conv_q;

  assign line_o   = coded ? (half_q ? ~lvl : lvl) : 1'b1;
  assign hclk_o   = coded & ~half_q;
  assign busy_o   = (st_q != S_IDLE);
  assign in_ready = ~busy_o;
  assign done_o   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      half_q <= 1'b0;
      cnt_q  <= '0;
      div_q  <= '0;
      idx_q  <= '0;
      len_q  <= '0;
      stop_q <= '0;
      data_q <= '0;
      conv_q <= 1'b0;
      msb_q  <= 1'b0;
      sval_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q == S_IDLE) begin
        if (in_valid) begin
          data_q <= in_data;
          len_q  <= in_len;
          conv_q <= in_conv;
          msb_q  <= in_msb_first;
          sval_q <= (in_start_mode == 2'd2);
          div_q  <= half_div;
          cnt_q  <= '0;
          half_q <= 1'b0;
          idx_q  <= '0;
          stop_q <= '0;
          st_q   <= (in_start_mode == 2'd1 || in_start_mode == 2'd2) ? S_START : S_DATA;
        end
      end else if (tick) begin
        cnt_q  <= '0;
        half_q <= ~half_q;
        case (st_q)
          S_START: if (half_q) st_q <= S_DATA;
          S_DATA: if (half_q) begin
            if (idx_q == len_q) st_q <= S_STOP;
            else idx_q <= idx_q + 1'b1;
          end
          S_STOP: begin
            stop_q <= stop_q + 1'b1;
            if (stop_q == 2'd3) begin
              st_q   <= S_IDLE;
              done_q <= 1'b1;
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (line_o && !hclk_o));

  assert_stop_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_STOP) |-> (line_o && busy_o));

  assert_half_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && $past(cnt_q != div_q)) |-> $stable(line_o));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(data_q) && $stable(len_q) && $stable(div_q)));

endmodule

// File: tb/manchester_frame_tx_bench.sv
`timescale 1ns/1ps
module manchester_frame_tx_bench;
  localparam int DATA_W = 16;
  localparam int DIV_W  = 16;
  localparam int LEN_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic [LEN_W-1:0]  in_len = '0;
  logic in_conv = 1'b0, in_msb_first = 1'b0;
  logic [1:0] in_start_mode = '0;
  logic [DIV_W-1:0] half_div = '0;
  logic line_o, hclk_o, busy_o, done_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  manchester_frame_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_manchester_frame_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_len(in_len), .in_conv(in_conv),
    .in_msb_first(in_msb_first), .in_start_mode(in_start_mode),
    .half_div(half_div), .line_o(line_o), .hclk_o(hclk_o),
    .busy_o(busy_o), .done_o(done_o));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int n_start(input logic [1:0] m);
    return (m == 2'd1 || m == 2'd2) ? 1 : 0;
  endfunction

  function automatic logic exp_line(input logic [DATA_W-1:0] d, input int len,
      input logic cv, input logic msb, input logic [1:0] m, input int dv, input int p,
      output logic hc);
    int h, slot, ns, b;
    logic v, lv;
    ns = n_start(m);
    h = p / (dv + 1);
    slot = h / 2;
    hc = 1'b0;
    if (slot < ns) v = (m == 2'd2);
    else if (slot < ns + len + 1) begin
      b = slot - ns;
      v = msb ? d[len - b] : d[b];
    end else return 1'b1;
    lv = v ^ cv;
    hc = (h % 2 == 0);
    return (h % 2 == 1) ? ~lv : lv;
  endfunction

  task automatic idle_check(input string tag);
    check(line_o == 1'b1, tag, line_o, 1);
    check({hclk_o, busy_o, done_o, in_ready} == 4'b0001, tag,
          {hclk_o, busy_o, done_o, in_ready}, 1);
  endtask

  // Caller is at a negedge. Returns at the negedge of the done cycle.
  task automatic run_frame(input logic [DATA_W-1:0] d, input int len, input logic cv,
      input logic msb, input logic [1:0] m, input int dv, input bit poke, input string tag);
    int t, bad_line, bad_hclk, bad_busy, bad_stop, first_p;
    logic el, eh, al;
    t = (n_start(m) + len + 1 + 2) * 2 * (dv + 1);
    in_data = d; in_len = LEN_W'(len); in_conv = cv; in_msb_first = msb;
    in_start_mode = m; half_div = DIV_W'(dv); in_valid = 1'b1;
    bad_line = 0; bad_hclk = 0; bad_busy = 0; bad_stop = 0; first_p = -1; al = 1'b0;
    el = 1'b0;
    for (int k = 1; k <= t + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin
        in_valid = 1'b0;
        check(busy_o == 1'b1 && in_ready == 1'b0, {tag, " R9 busy after accept"}, busy_o, 1);
      end
      if (poke && k == 3) begin
        in_valid = 1'b1; in_data = ~d; in_len = ~LEN_W'(len); in_conv = ~cv;
        in_msb_first = ~msb; in_start_mode = ~m; half_div = DIV_W'(dv + 3);
      end
      if (poke && k == 5) in_valid = 1'b0;
      if (k <= t) begin
        el = exp_line(d, len, cv, msb, m, dv, k - 1, eh);
        if (line_o !== el) begin
          bad_line++;
          if (first_p < 0) begin first_p = k - 1; al = line_o; end
        end
        if (hclk_o !== eh) bad_hclk++;
        if (busy_o !== 1'b1 || done_o !== 1'b0) bad_busy++;
        if (k > t - 4 * (dv + 1) && line_o !== 1'b1) bad_stop++;
      end else begin
        check(done_o == 1'b1 && busy_o == 1'b0, {tag, " R9 done pulse at frame end"}, done_o, 1);
        check(in_ready == 1'b1 && line_o == 1'b1, {tag, " R9 ready in done cycle"}, in_ready, 1);
      end
    end
    if (bad_line != 0)
      $display("  first line mismatch at sample %0d: got %0d", first_p, al);
    check(bad_line == 0, {tag, " line pattern"}, bad_line, 0);
    check(bad_hclk == 0, {tag, " R8 half-bit clock"}, bad_hclk, 0);
    check(bad_busy == 0, {tag, " R7 busy through frame"}, bad_busy, 0);
    check(bad_stop == 0, {tag, " R7 stop periods high"}, bad_stop, 0);
  endtask

  task automatic gap(input string tag);
    @(negedge clk);
    idle_check(tag);
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    idle_check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1 after reset");
    in_valid = 1'b0;

    run_frame(16'h00A5, 7, 1'b0, 1'b0, 2'd0, 1, 0, "R2 conv0"); gap("R1 between frames");
    run_frame(16'h00A5, 7, 1'b1, 1'b0, 2'd0, 1, 0, "R3 conv1"); gap("R1 R9 done once");
    run_frame(16'hFFFF, 0, 1'b0, 1'b0, 2'd0, 0, 0, "R4 len0");  gap("R1");
    run_frame(16'h8001, 15, 1'b1, 1'b0, 2'd0, 0, 0, "R4 full"); gap("R1");
    run_frame(16'h0031, 5, 1'b0, 1'b1, 2'd0, 2, 0, "R5 msb");   gap("R1");
    run_frame(16'h0031, 5, 1'b0, 1'b0, 2'd0, 2, 0, "R5 lsb");   gap("R1");
    run_frame(16'h0003, 3, 1'b0, 1'b0, 2'd1, 1, 0, "R6 mode1"); gap("R1");
    run_frame(16'h0003, 3, 1'b1, 1'b0, 2'd2, 1, 0, "R6 mode2"); gap("R1");
    run_frame(16'h0003, 3, 1'b0, 1'b1, 2'd3, 1, 0, "R6 mode3"); gap("R1");
    run_frame(16'h5A3C, 11, 1'b0, 1'b0, 2'd2, 4, 0, "R8 div4"); gap("R1");
    run_frame(16'h1234, 9, 1'b1, 1'b1, 2'd1, 2, 1, "R10 poke");  gap("R1 R10 after poke");
    // back-to-back: next word offered in the done cycle
    run_frame(16'h0F0F, 7, 1'b0, 1'b0, 2'd2, 1, 0, "R9 chain a");
    run_frame(16'hF0F0, 7, 1'b1, 1'b1, 2'd1, 0, 0, "R9 chain b");
    run_frame(16'h0001, 0, 1'b0, 1'b0, 2'd0, 0, 0, "R9 chain c");
    gap("R1");

    for (int i = 0; i < 40; i++) begin
      logic [DATA_W-1:0] d;
      int len, dv;
      logic cv, msb;
      logic [1:0] m;
      d = DATA_W'($urandom());
      len = int'($urandom_range(0, DATA_W - 1));
      dv = int'($urandom_range(0, 3));
      cv = 1'($urandom_range(0, 1));
      msb = 1'($urandom_range(0, 1));
      m = 2'($urandom_range(0, 3));
      run_frame(d, len, cv, msb, m, dv, ($urandom_range(0, 3) == 0),
                cv ? "R3 random" : "R2 random");
      if ($urandom_range(0, 1) == 0) gap("R1 random gap");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule